// File: doc/BRIEF.md
# Two-Beat Double-Rate SRAM Core

This block is a synthesizable behavioural model of a synchronous static memory with a read data port and a write data port that work independently. Both ports carry two beats for every command, and one command may start each clock period. The block runs on a single clock at twice the command rate. Each cycle of that clock is one half-period slot. The block keeps track of the slots itself and reports whether the current cycle is an odd slot.

A read and a write may be issued in the same slot. They share one address bus, so both act on the same address. Address and control are registered on input. Write data is collected over two slots and merged into the array one slot after its second beat. The read path is pipelined, so data leaves three slots after the command. A read always sees every write issued in the same or an earlier command slot. A write that has not yet reached the array is merged into the read result one byte lane at a time.

Top module: `b2_ddr_sram`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rvalid` is 0, `rdata` is 0 and `beat_odd` is 0.
- R2: `beat_odd` is 0 in the first cycle after reset and toggles on every later cycle.
- R3: `rd_en`, `wr_en` and `addr` are sampled only in cycles where `beat_odd` is 0. Their values in odd cycles have no effect.
- R4: For a write command in cycle t, `wdata`/`wbe` in cycle t form beat 0 and `wdata`/`wbe` in cycle t+1 form beat 1. The pair is stored at `addr` as one word, with beat 0 in the lower half.
- R5: Bit i of `wbe` enables bits [9i+8:9i] of `wdata` for its own beat. Lanes whose enable is 0 keep the value stored before.
- R6: For a read command in cycle t, `rvalid` is 1 in cycles t+3 and t+4. `rdata` carries beat 0 in cycle t+3 and beat 1 in cycle t+4.
- R7: In any cycle not covered by R6, `rvalid` is 0 and `rdata` is 0.
- R8: A read returns the combined effect of every write commanded in the same cycle or an earlier even cycle, merged per byte lane. It shows nothing of a write commanded in a later cycle.
- R9: Reads commanded in consecutive even cycles produce an unbroken run of `rvalid` with no idle cycle between bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, two cycles per command period |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read command, sampled in even slots |
| wr_en | input | 1 | Write command, sampled in even slots |
| addr | input | 6 | Shared word address for read and write |
| wdata | input | 36 | Write beat: beat 0 in the command slot, beat 1 in the slot after |
| wbe | input | 4 | Byte-lane write enables for the current write beat |
| rdata | output | 36 | Read beat, zero when no beat is valid |
| rvalid | output | 1 | High for each of the two read beats |
| beat_odd | output | 1 | High in the second slot of each command period |

## Verification
The assertions assume the environment issues commands only while `beat_odd` is 0 when checking read latency. They also assume that after reset `rst` stays low, so the slot parity never breaks. The stimulus drives all inputs on the falling clock edge and aligns every command to an even slot. It deliberately puts junk commands and a different address on the bus in odd slots, so that R3 is tested on every operation without disturbing the expected read stream. Reads are issued only after every address has been written once, so no expected value depends on uninitialised storage.

// File: rtl/b2sram_pkg.sv
package b2sram_pkg;

    parameter int unsigned BEAT_W = 36;
    parameter int unsigned LANES  = 4;
    parameter int unsigned ADDR_W = 6;

    localparam int unsigned LANE_W = BEAT_W / LANES;
    localparam int unsigned WORD_W = 2 * BEAT_W;
    localparam int unsigned WLANES = 2 * LANES;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    typedef logic [BEAT_W-1:0] beat_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  bmask_t;
    typedef logic [WLANES-1:0] wmask_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Position of the current cycle inside one command period
    typedef enum logic {
        SLOT_EVEN = 1'b0,
        SLOT_ODD  = 1'b1
    } slot_e;

    typedef struct packed {
        logic  rd;
        logic  wr;
        addr_t addr;
    } cmd_t;

    typedef struct packed {
        beat_t  data;
        bmask_t mask;
    } wbeat_t;

    typedef struct packed {
        logic   vld;
        addr_t  addr;
        word_t  data;
        wmask_t mask;
    } wpend_t;

    // Overlay the enabled lanes of upd onto base
    function automatic word_t lane_merge(word_t base, word_t upd, wmask_t m);
        word_t r;
        r = base;
        for (int i = 0; i < int'(WLANES); i++) begin
            if (m[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/b2_cmd_reg.sv
module b2_cmd_reg
    import b2sram_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rd_en,
    input  logic   wr_en,
    input  addr_t  addr,
    input  beat_t  wdata,
    input  bmask_t wbe,
    output slot_e  slot,
    output cmd_t   cmd,
    output wbeat_t beat0
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot  <= SLOT_EVEN;
            cmd   <= '0;
            beat0 <= '0;
        end else begin
            slot <= (slot == SLOT_EVEN) ? SLOT_ODD : SLOT_EVEN;
            if (slot == SLOT_EVEN) begin
                cmd.rd     <= rd_en;
                cmd.wr     <= wr_en;
                cmd.addr   <= addr;
                beat0.data <= wdata;
                beat0.mask <= wbe;
            end
        end
    end

endmodule

// File: rtl/b2_wr_stage.sv
module b2_wr_stage
    import b2sram_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  slot_e  slot,
    input  logic   wr_go,
    input  addr_t  wr_addr,
    input  wbeat_t beat0,
    input  beat_t  wdata,
    input  bmask_t wbe,
    output wpend_t pend
);

    // Odd edge: second beat lands and the burst becomes pending.
    // Even edge: the array absorbs it, so the entry retires.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (slot == SLOT_ODD) begin
            pend.vld  <= wr_go;
            pend.addr <= wr_addr;
            pend.data <= {wdata, beat0.data};
            pend.mask <= {wbe, beat0.mask};
        end else begin
            pend.vld <= 1'b0;
        end
    end

endmodule

// File: rtl/b2_store.sv
module b2_store
    import b2sram_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  slot_e  slot,
    input  logic   rd_go,
    input  addr_t  rd_addr,
    input  wpend_t pend,
    output logic   look_v,
    output word_t  look_word
);

    word_t  mem [DEPTH];
    logic   rq_v;
    addr_t  rq_addr;
    wmask_t fwd_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_v    <= 1'b0;
            rq_addr <= '0;
        end else if (slot == SLOT_ODD) begin
            rq_v    <= rd_go;
            rq_addr <= rd_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (slot == SLOT_EVEN && pend.vld) begin
            mem[pend.addr] <= lane_merge(mem[pend.addr], pend.data, pend.mask);
        end
    end

    // The pending burst has not reached the array yet: overlay its lanes
    always_comb begin
        fwd_mask  = (pend.vld && pend.addr == rq_addr) ? pend.mask : '0;
        look_word = lane_merge(mem[rq_addr], pend.data, fwd_mask);
        look_v    = rq_v && (slot == SLOT_EVEN);
    end

endmodule

// File: rtl/b2_rd_out.sv
module b2_rd_out
    import b2sram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  look_v,
    input  word_t look_word,
    output beat_t rdata,
    output logic  rvalid
);

    beat_t hi_q;
    logic  hi_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            hi_q   <= '0;
            hi_v   <= 1'b0;
        end else if (look_v) begin
            rdata  <= look_word[BEAT_W-1:0];
            hi_q   <= look_word[WORD_W-1:BEAT_W];
            hi_v   <= 1'b1;
            rvalid <= 1'b1;
        end else if (hi_v) begin
            rdata  <= hi_q;
            hi_v   <= 1'b0;
            rvalid <= 1'b1;
        end else begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/b2_ddr_sram.sv
module b2_ddr_sram
    import b2sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BEAT_W-1:0] wdata,
    input  logic [LANES-1:0]  wbe,
    output logic [BEAT_W-1:0] rdata,
    output logic              rvalid,
    output logic              beat_odd
);

    slot_e  slot;
    cmd_t   cmd;
    wbeat_t beat0;
    wpend_t pend;
    logic   look_v;
    word_t  look_word;

    b2_cmd_reg i_cmd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .wbe   (wbe),
        .slot  (slot),
        .cmd   (cmd),
        .beat0 (beat0)
    );

    b2_wr_stage i_wr (
        .clk     (clk),
        .rst     (rst),
        .slot    (slot),
        .wr_go   (cmd.wr),
        .wr_addr (cmd.addr),
        .beat0   (beat0),
        .wdata   (wdata),
        .wbe     (wbe),
        .pend    (pend)
    );

    b2_store i_store (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .rd_go     (cmd.rd),
        .rd_addr   (cmd.addr),
        .pend      (pend),
        .look_v    (look_v),
        .look_word (look_word)
    );

    b2_rd_out i_out (
        .clk       (clk),
        .rst       (rst),
        .look_v    (look_v),
        .look_word (look_word),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    assign beat_odd = (slot == SLOT_ODD);

endmodule

// File: rtl/b2_ddr_sram_chk.sv
module b2_ddr_sram_chk
    import b2sram_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [BEAT_W-1:0] rdata,
    input logic              rvalid,
    input logic              beat_odd
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!rvalid && !beat_odd && rdata == '0));

    p_slot_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (beat_odd != $past(beat_odd)));

    p_read_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !beat_odd) |-> ##3 rvalid);

    p_first_beat_odd_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |-> beat_odd);

    p_pair_complete_r6: assert property (@(posedge clk) disable iff (rst)
        (rvalid && beat_odd) |=> rvalid);

    p_read_source_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |-> $past(rd_en && !beat_odd, 3));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0));

endmodule

bind b2_ddr_sram b2_ddr_sram_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .beat_odd (beat_odd)
);

// File: tb/test_b2_ddr_sram.sv
`timescale 1ns/1ps
module test_b2_ddr_sram;
    import b2sram_pkg::*;

    logic   clk = 1'b0;
    logic   rst = 1'b1;
    logic   rd_en = 1'b0;
    logic   wr_en = 1'b0;
    addr_t  addr = '0;
    beat_t  wdata = '0;
    bmask_t wbe = '0;
    beat_t  rdata;
    logic   rvalid;
    logic   beat_odd;

    int    checks = 0;
    int    fails = 0;
    int    slot_n = 0;
    string cur_req = "R1";

    word_t ref_mem [DEPTH];
    logic  exp_v [8];
    beat_t exp_d [8];

    b2_ddr_sram i_b2_ddr_sram (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .wbe      (wbe),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .beat_odd (beat_odd)
    );

    always #10 clk = ~clk;

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    function automatic beat_t pat(int a, int b, int s);
        return beat_t'((a + 1) * 32'h09E3_779B + b * 32'h0123_4567 + s * 32'h0005_0F1D);
    endfunction

    // R5: lane i of a beat is bits [9i+8:9i]; expand the 8 lane enables to bits
    task automatic ref_write(input addr_t a, input word_t d, input wmask_t m);
        word_t bm;
        for (int j = 0; j < int'(WORD_W); j++) bm[j] = m[j / LANE_W];
        ref_mem[a] = (ref_mem[a] & ~bm) | (d & bm);
    endtask

    task automatic check_slot();
        int k;
        string lbl;
        k = slot_n % 8;
        checks++;
        if (beat_odd !== slot_n[0]) begin
            fails++;
            $display("FAIL R2 slot %0d: beat_odd actual %b expected %b", slot_n, beat_odd, slot_n[0]);
        end
        lbl = exp_v[k] ? cur_req : {"R7/", cur_req};
        checks++;
        if (rvalid !== exp_v[k] || rdata !== exp_d[k]) begin
            fails++;
            $display("FAIL %s slot %0d: rvalid/rdata actual %b/%h expected %b/%h",
                     lbl, slot_n, rvalid, rdata, exp_v[k], exp_d[k]);
        end
        exp_v[k] = 1'b0;
        exp_d[k] = '0;
    endtask

    task automatic advance();
        @(negedge clk);
        slot_n++;
    endtask

    // One command period: even slot carries the command, odd slot beat 1 plus junk
    task automatic op(input logic rd, input logic wr, input int a,
                      input beat_t d0, input beat_t d1, input bmask_t m0, input bmask_t m1);
        check_slot();
        rd_en = rd;
        wr_en = wr;
        addr  = addr_t'(a);
        wdata = d0;
        wbe   = m0;
        if (wr) ref_write(addr_t'(a), {d1, d0}, {m1, m0});
        if (rd) begin
            exp_v[(slot_n + 3) % 8] = 1'b1;
            exp_d[(slot_n + 3) % 8] = ref_mem[a][BEAT_W-1:0];
            exp_v[(slot_n + 4) % 8] = 1'b1;
            exp_d[(slot_n + 4) % 8] = ref_mem[a][WORD_W-1:BEAT_W];
        end
        advance();
        check_slot();
        rd_en = 1'b1;            // R3: odd-slot commands must be ignored
        wr_en = 1'b1;
        addr  = ~addr_t'(a);
        wdata = d1;
        wbe   = m1;
        advance();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 0, '0, '0, '0, '0);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin
            exp_v[k] = 1'b0;
            exp_d[k] = '0;
        end
        for (int a = 0; a < int'(DEPTH); a++) ref_mem[a] = '0;

        // R1: outputs quiet while reset is held
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            checks++;
            if (rvalid !== 1'b0 || rdata !== '0 || beat_odd !== 1'b0) begin
                fails++;
                $display("FAIL R1: rvalid/rdata/beat_odd actual %b/%h/%b expected 0/0/0",
                         rvalid, rdata, beat_odd);
            end
        end
        rst = 1'b0;
        slot_n = 0;

        cur_req = "R4";
        for (int a = 0; a < int'(DEPTH); a++) op(1'b0, 1'b1, a, pat(a, 0, 0), pat(a, 1, 0), '1, '1);

        cur_req = "R9";
        for (int a = 0; a < int'(DEPTH); a++) op(1'b1, 1'b0, a, '0, '0, '0, '0);

        cur_req = "R6";
        for (int a = 0; a < 8; a++) begin
            op(1'b1, 1'b0, a * 7, '0, '0, '0, '0);
            idle(2);
        end

        cur_req = "R3";
        idle(6);

        cur_req = "R5";
        for (int m = 0; m < 256; m++) begin
            op(1'b0, 1'b1, m % 64, pat(m, 0, 3), pat(m, 1, 3), bmask_t'(m), bmask_t'(m >> 4));
            op(1'b1, 1'b0, m % 64, '0, '0, '0, '0);
        end

        cur_req = "R8";
        for (int a = 0; a < 32; a++) begin
            op(1'b1, 1'b1, a, pat(a, 0, 5), pat(a, 1, 5), bmask_t'(a), bmask_t'(~a));
            op(1'b0, 1'b1, a, pat(a, 0, 6), pat(a, 1, 6), 4'b0110, 4'b1001);
            op(1'b1, 1'b0, a, '0, '0, '0, '0);
            op(1'b1, 1'b0, a, '0, '0, '0, '0);
            op(1'b0, 1'b1, a, pat(a, 0, 7), pat(a, 1, 7), '1, '1);
            idle(1);
        end
        for (int i = 0; i < 1500; i++) begin
            op(1'(($urandom >> 3) & 1), 1'(($urandom >> 5) & 1), int'($urandom % 8),
               beat_t'({$urandom, $urandom}), beat_t'({$urandom, $urandom}),
               bmask_t'($urandom), bmask_t'($urandom));
        end

        cur_req = "R7";
        idle(6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule